// File: doc/BRIEF.md
# Bridge Quiesce and Reset Sequencer

This block owns one functional sub-domain that reaches the rest of the chip through two asynchronous bus bridges, a master-side bridge and a slave-side bridge. It drives the sub-domain's clock enable and its active-low reset, and it drives a stop-request line to each bridge while watching that bridge's acknowledge line. The parent power domain is assumed to be up already.

Software issues a 32-bit command write. The write only takes effect if its top byte carries the key 0x5A and the block is idle. Three commands are supported. Enable brings the sub-domain out of reset and reconnects it. Disable quiesces it and puts it back into reset. Reset-pulse runs a disable followed by an enable.

Each bridge handshake is given a bounded wait. When a handshake times out, the block undoes the part of the sequence it has already done and reports an error. A parameter removes the bridges, and in that variant only the clock and reset steps run.

Top module: `bridge_rst_seq`

## Requirements
- R1: After reset, `dom_clk_en`=0, `dom_rst_n`=0, `mst_stop`=1, `slv_stop`=1, `busy`=0, `done`=0 and `err`=0.
- R2: A command write is accepted only if `cmd_data[31:24]`=0x5A and the opcode `cmd_data[1:0]` is nonzero. The opcodes are 01 for enable, 10 for disable and 11 for reset-pulse. Any other write leaves every output unchanged.
- R3: Enable turns the clock on for exactly `PROP_CYCLES` cycles (default 32), then gates it off. It releases `dom_rst_n` only while the clock is gated, and then turns the clock back on.
- R4: After the reset is released, enable clears `mst_stop` and waits for `mst_ack`=0. Only then does it clear `slv_stop`. A successful enable leaves both stop lines low.
- R5: Disable raises `slv_stop` first and waits for `slv_ack`=1. It then raises `mst_stop` and waits for `mst_ack`=1. It then gates the clock, and it asserts the reset no earlier than one cycle after the clock is gated.
- R6: If the master acknowledge does not fall within `ACK_WAIT` cycles during enable, the block gates the clock, asserts the reset and ends with `err`=1.
- R7: If the slave acknowledge does not fall within `ACK_WAIT` cycles during enable, the block raises `mst_stop` again and waits for the master acknowledge. It then gates the clock, asserts the reset and ends with `err`=1.
- R8: If the slave acknowledge does not rise within `ACK_WAIT` cycles during disable, the block aborts with `err`=1. The clock, the reset and `mst_stop` are left unchanged.
- R9: If the master acknowledge does not rise within `ACK_WAIT` cycles during disable, the block clears `slv_stop` again and ends with `err`=1. The clock and the reset stay on.
- R10: Reset-pulse performs a complete disable and then a complete enable. `rst_status` is high at some point while the command runs, and a single `done` marks its end.
- R11: While `busy`=1, command writes are ignored, including one present in the cycle that completes a request.
- R12: `busy` is high from the cycle after acceptance until completion. `done` pulses for one cycle as `busy` falls. `err` holds the outcome until the next accepted command. `rst_status` equals the inverse of `dom_rst_n`.
- R13: With `HAS_BRIDGE`=0, both stop lines stay high and no handshake runs. Enable, disable and reset-pulse perform only their clock and reset steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 32 | Command word: key in [31:24], opcode in [1:0] |
| mst_ack | input | 1 | Master bridge acknowledge |
| slv_ack | input | 1 | Slave bridge acknowledge |
| mst_stop | output | 1 | Master bridge stop request |
| slv_stop | output | 1 | Slave bridge stop request |
| dom_clk_en | output | 1 | Sub-domain clock enable |
| dom_rst_n | output | 1 | Sub-domain reset, active low |
| rst_status | output | 1 | High while the sub-domain reset is asserted |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at request completion |
| err | output | 1 | Outcome of the last request (1 = failed) |

## Verification
A command write can land in the same cycle that the sequencer completes a request. That write must be dropped, because the block is still busy on that edge. The bench provokes this by holding a keyed disable write on `cmd_wr` for the whole length of an enable request and removing it only at the sampling point where `done` is seen. It then judges the result by checking that `busy` stays low afterwards and that the clock and reset remain in their enabled state. A scoreboard compares the final output state of every request, including each timeout rollback forced through a stuck acknowledge, against values predicted from the requirements.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam logic [7:0] WR_KEY   = 8'h5A;
  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_ON    = 2'b01;
  localparam logic [1:0] OP_OFF   = 2'b10;
  localparam logic [1:0] OP_PULSE = 2'b11;
  localparam int         BR_MST   = 0;
  localparam int         BR_SLV   = 1;
  localparam int         NBR      = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_PROP,
    S_EN_GATE,
    S_EN_CLK,
    S_EN_MST,
    S_EN_SLV,
    S_EN_RBK,
    S_DIS_SLV,
    S_DIS_MST,
    S_DIS_RBK,
    S_DIS_GATE
  } seq_st_e;
endpackage

// File: rtl/brs_cmd_dec.sv
module brs_cmd_dec
  import brs_pkg::*;
(
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  output logic        want_on,
  output logic        want_off,
  output logic        want_pulse
);
  logic key_ok;
  assign key_ok     = cmd_wr && (cmd_data[31:24] == WR_KEY);
  assign want_on    = key_ok && (cmd_data[1:0] == OP_ON);
  assign want_off   = key_ok && (cmd_data[1:0] == OP_OFF);
  assign want_pulse = key_ok && (cmd_data[1:0] == OP_PULSE);
endmodule

// File: rtl/brs_handshake.sv
module brs_handshake #(
  parameter int ACK_WAIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_stop,
  input  logic ack,
  output logic stop_req,
  output logic ok,
  output logic tmo
);
  localparam int CW = $clog2(ACK_WAIT + 1);

  logic          stop_q, stop_d;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign ok       = act_q && (ack == stop_q);
  assign tmo      = act_q && (ack != stop_q) && (cnt_q == CW'(ACK_WAIT - 1));
  assign stop_req = stop_q;

  always_comb begin
    stop_d = stop_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (go) begin
      stop_d = go_stop;
      act_d  = 1'b1;
      cnt_d  = '0;
    end else if (ok || tmo) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stop_q <= stop_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8/R9: a stop line is held steady while its acknowledge is awaited
  a_r8_stop_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !ok && !tmo && !go) |=> $stable(stop_req));
  // R6: a timeout is only reported after a wait that was already running
  a_r6_tmo_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> $past(act_q));
endmodule

// File: rtl/brs_seq_fsm.sv
module brs_seq_fsm
  import brs_pkg::*;
#(
  parameter bit HAS_BRIDGE  = 1'b1,
  parameter int PROP_CYCLES = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           want_on,
  input  logic           want_off,
  input  logic           want_pulse,
  input  logic [NBR-1:0] hs_ok,
  input  logic [NBR-1:0] hs_tmo,
  output logic [NBR-1:0] hs_go,
  output logic [NBR-1:0] hs_stop,
  output logic           clk_en,
  output logic           sub_rst_n,
  output logic           busy,
  output logic           done,
  output logic           err
);
  localparam int PW = (PROP_CYCLES > 1) ? $clog2(PROP_CYCLES) : 1;

  seq_st_e       st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d, srst_q, srst_d;
  logic          pls_q, pls_d, fail_q, fail_d;
  logic          done_q, done_d, err_q, err_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    clk_d  = clk_q;
    srst_d = srst_q;
    pls_d  = pls_q;
    fail_d = fail_q;
    err_d  = err_q;
    done_d = 1'b0;
    hs_go  = '0;
    hs_stop = '0;
    case (st_q)
      S_IDLE: begin
        if (want_on) begin
          st_d = S_EN_PROP; clk_d = 1'b1; cnt_d = '0;
          err_d = 1'b0; pls_d = 1'b0; fail_d = 1'b0;
        end else if (want_off || want_pulse) begin
          err_d = 1'b0; pls_d = want_pulse; fail_d = 1'b0;
          if (HAS_BRIDGE) begin
            hs_go[BR_SLV] = 1'b1; hs_stop[BR_SLV] = 1'b1; st_d = S_DIS_SLV;
          end else begin
            clk_d = 1'b0; st_d = S_DIS_GATE;
          end
        end
      end
      S_EN_PROP: begin
        if (cnt_q == PW'(PROP_CYCLES - 1)) begin
          clk_d = 1'b0; st_d = S_EN_GATE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_EN_GATE: begin
        srst_d = 1'b1; st_d = S_EN_CLK;
      end
      S_EN_CLK: begin
        clk_d = 1'b1;
        if (HAS_BRIDGE) begin
          hs_go[BR_MST] = 1'b1; st_d = S_EN_MST;
        end else begin
          st_d = S_IDLE; done_d = 1'b1;
        end
      end
      S_EN_MST: begin
        if (hs_ok[BR_MST]) begin
          hs_go[BR_SLV] = 1'b1; st_d = S_EN_SLV;
        end else if (hs_tmo[BR_MST]) begin
          clk_d = 1'b0; fail_d = 1'b1; st_d = S_DIS_GATE;
        end
      end
      S_EN_SLV: begin
        if (hs_ok[BR_SLV]) begin
          st_d = S_IDLE; done_d = 1'b1;
        end else if (hs_tmo[BR_SLV]) begin
          hs_go[BR_MST] = 1'b1; hs_stop[BR_MST] = 1'b1; st_d = S_EN_RBK;
        end
      end
      S_EN_RBK: begin
        if (hs_ok[BR_MST] || hs_tmo[BR_MST]) begin
          clk_d = 1'b0; fail_d = 1'b1; st_d = S_DIS_GATE;
        end
      end
      S_DIS_SLV: begin
        if (hs_ok[BR_SLV]) begin
          hs_go[BR_MST] = 1'b1; hs_stop[BR_MST] = 1'b1; st_d = S_DIS_MST;
        end else if (hs_tmo[BR_SLV]) begin
          st_d = S_IDLE; done_d = 1'b1; err_d = 1'b1;
        end
      end
      S_DIS_MST: begin
        if (hs_ok[BR_MST]) begin
          clk_d = 1'b0; st_d = S_DIS_GATE;
        end else if (hs_tmo[BR_MST]) begin
          hs_go[BR_SLV] = 1'b1; st_d = S_DIS_RBK;
        end
      end
      S_DIS_RBK: begin
        if (hs_ok[BR_SLV] || hs_tmo[BR_SLV]) begin
          st_d = S_IDLE; done_d = 1'b1; err_d = 1'b1;
        end
      end
      S_DIS_GATE: begin
        srst_d = 1'b0;
        if (fail_q) begin
          st_d = S_IDLE; done_d = 1'b1; err_d = 1'b1;
        end else if (pls_q) begin
          pls_d = 1'b0; clk_d = 1'b1; cnt_d = '0; st_d = S_EN_PROP;
        end else begin
          st_d = S_IDLE; done_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      srst_q <= 1'b0;
      pls_q  <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      clk_q  <= clk_d;
      srst_q <= srst_d;
      pls_q  <= pls_d;
      fail_q <= fail_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign clk_en    = clk_q;
  assign sub_rst_n = srst_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  // R3: reset is released only while the clock is gated
  a_r3_release_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_q) |-> !clk_q);
  // R5: reset is asserted no earlier than one cycle after the clock is gated
  a_r5_gate_then_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> $past(!clk_q));
  // R12: completion pulse coincides with the return to idle
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == S_IDLE) && $past(st_q != S_IDLE));
endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
  import brs_pkg::*;
#(
  parameter bit HAS_BRIDGE  = 1'b1,
  parameter int PROP_CYCLES = 32,
  parameter int ACK_WAIT    = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  input  logic        mst_ack,
  input  logic        slv_ack,
  output logic        mst_stop,
  output logic        slv_stop,
  output logic        dom_clk_en,
  output logic        dom_rst_n,
  output logic        rst_status,
  output logic        busy,
  output logic        done,
  output logic        err
);
  logic           want_on, want_off, want_pulse;
  logic [NBR-1:0] hs_go, hs_stop, hs_ok, hs_tmo, ack_v, stop_v;

  brs_cmd_dec u_dec (
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .want_on   (want_on),
    .want_off  (want_off),
    .want_pulse(want_pulse)
  );

  brs_seq_fsm #(.HAS_BRIDGE(HAS_BRIDGE), .PROP_CYCLES(PROP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_on   (want_on),
    .want_off  (want_off),
    .want_pulse(want_pulse),
    .hs_ok     (hs_ok),
    .hs_tmo    (hs_tmo),
    .hs_go     (hs_go),
    .hs_stop   (hs_stop),
    .clk_en    (dom_clk_en),
    .sub_rst_n (dom_rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  assign ack_v[BR_MST] = mst_ack;
  assign ack_v[BR_SLV] = slv_ack;

  for (genvar b = 0; b < NBR; b++) begin : g_br
    brs_handshake #(.ACK_WAIT(ACK_WAIT)) u_hs (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (hs_go[b]),
      .go_stop (hs_stop[b]),
      .ack     (ack_v[b]),
      .stop_req(stop_v[b]),
      .ok      (hs_ok[b]),
      .tmo     (hs_tmo[b])
    );
  end

  assign mst_stop   = stop_v[BR_MST];
  assign slv_stop   = stop_v[BR_SLV];
  assign rst_status = !dom_rst_n;

  // R2: a write without the key never starts a request
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && (cmd_data[31:24] != WR_KEY)) |=> !busy);
  // R13: without bridges the stop lines never drop
  a_r13_no_bridge_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_BRIDGE |-> (mst_stop && slv_stop));
endmodule

// File: tb/tb_bridge_rst_seq.sv
module tb_bridge_rst_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr, nb_wr;
  logic [31:0] cmd_data, nb_data;
  logic        mst_ack, slv_ack, stuck_m, stuck_s;
  logic        mst_stop, slv_stop, dom_clk_en, dom_rst_n, rst_status, busy, done, err;
  logic        nb_mst, nb_slv, nb_clk, nb_rst, nb_rs, nb_busy, nb_done, nb_err;
  logic [2:0]  md, sd;
  int          n_cmp = 0, n_bad = 0, cyc = 0, run_len = 0;
  logic        prev_clk, prev_rst, prev_slv, prev_mst, saw_rs;
  logic [4:0]  expq[$];
  string       tagq[$];

  always #10 clk = ~clk;

  bridge_rst_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .mst_ack(mst_ack), .slv_ack(slv_ack), .mst_stop(mst_stop), .slv_stop(slv_stop),
    .dom_clk_en(dom_clk_en), .dom_rst_n(dom_rst_n), .rst_status(rst_status),
    .busy(busy), .done(done), .err(err));

  bridge_rst_seq #(.HAS_BRIDGE(1'b0)) dut_nb (
    .clk(clk), .rst_n(rst_n), .cmd_wr(nb_wr), .cmd_data(nb_data),
    .mst_ack(1'b0), .slv_ack(1'b0), .mst_stop(nb_mst), .slv_stop(nb_slv),
    .dom_clk_en(nb_clk), .dom_rst_n(nb_rst), .rst_status(nb_rs),
    .busy(nb_busy), .done(nb_done), .err(nb_err));

  // bridge model: acknowledge follows stop request after a short delay unless stuck
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md <= '1; sd <= '1; mst_ack <= 1'b1; slv_ack <= 1'b1;
    end else begin
      md <= {md[1:0], mst_stop};
      sd <= {sd[1:0], slv_stop};
      if (!stuck_m) mst_ack <= md[2];
      if (!stuck_s) slv_ack <= sd[2];
    end
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // scoreboard monitor: final state at each completion {err,clk_en,rst_n,mst_stop,slv_stop}
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R12 unexpected done", 1, 0);
      end else begin
        logic [4:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({err, dom_clk_en, dom_rst_n, mst_stop, slv_stop} == e, t,
            {err, dom_clk_en, dom_rst_n, mst_stop, slv_stop}, e);
        chk(rst_status == !dom_rst_n, "R12 rst_status", rst_status, !dom_rst_n);
        chk(!busy, "R12 busy low at done", busy, 0);
      end
    end
  end

  // ordering monitors for R3, R4, R5 and pulse visibility for R10
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0; prev_clk = 0; prev_rst = 0; prev_slv = 1; prev_mst = 1;
    end else begin
      if (dom_clk_en) run_len++;
      else begin
        if (prev_clk && !dom_rst_n) chk(run_len == 32, "R3 propagate cycles", run_len, 32);
        run_len = 0;
      end
      if (dom_rst_n && !prev_rst) chk(!dom_clk_en, "R3 release while gated", dom_clk_en, 0);
      if (prev_slv && !slv_stop) chk(!mst_ack, "R4 master acked before slave released", mst_ack, 0);
      if (!prev_mst && mst_stop) chk(slv_ack, "R5 slave stopped before master", slv_ack, 1);
      if (busy && rst_status) saw_rs = 1'b1;
      prev_clk = dom_clk_en; prev_rst = dom_rst_n; prev_slv = slv_stop; prev_mst = mst_stop;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_up();
    end
  end

  task automatic run(input logic [7:0] key, input logic [1:0] op, input logic [4:0] e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = {key, 22'd0, op};
    @(negedge clk);
    cmd_wr = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_nb(input logic [1:0] op, input logic [4:0] e, input string tag);
    @(negedge clk);
    nb_wr = 1'b1; nb_data = {8'h5A, 22'd0, op};
    @(negedge clk);
    nb_wr = 1'b0;
    while (!nb_done) @(negedge clk);
    chk({nb_err, nb_clk, nb_rst, nb_mst, nb_slv} == e, tag, {nb_err, nb_clk, nb_rst, nb_mst, nb_slv}, e);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_data = '0; nb_wr = 1'b0; nb_data = '0;
    stuck_m = 1'b0; stuck_s = 1'b0; saw_rs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({dom_clk_en, dom_rst_n, mst_stop, slv_stop, busy, done, err} == 7'b0011000,
        "R1 reset state", {dom_clk_en, dom_rst_n, mst_stop, slv_stop, busy, done, err}, 7'b0011000);
    chk(rst_status, "R12 status in reset", rst_status, 1);

    // R2: wrong key, then keyed no-op
    cmd_wr = 1'b1; cmd_data = {8'hA5, 22'd0, 2'b01};
    @(negedge clk); cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !dom_clk_en, "R2 bad key ignored", {busy, dom_clk_en}, 0);
    cmd_wr = 1'b1; cmd_data = {8'h5A, 22'd0, 2'b00};
    @(negedge clk); cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !dom_clk_en && !dom_rst_n, "R2 null opcode ignored", {busy, dom_clk_en, dom_rst_n}, 0);

    // R3/R4 enable, R5 disable
    run(8'h5A, 2'b01, 5'b01100, "R4 enable result");
    run(8'h5A, 2'b10, 5'b00011, "R5 disable result");

    // R10 reset pulse from enabled state
    run(8'h5A, 2'b01, 5'b01100, "R4 enable before pulse");
    saw_rs = 1'b0;
    run(8'h5A, 2'b11, 5'b01100, "R10 pulse result");
    chk(saw_rs, "R10 reset seen during pulse", saw_rs, 1);

    // R9 master stop timeout (ack stuck low)
    stuck_m = 1'b1;
    run(8'h5A, 2'b10, 5'b11110, "R9 master stop timeout");
    stuck_m = 1'b0; settle();
    run(8'h5A, 2'b01, 5'b01100, "R9 recovery enable");

    // R8 slave stop timeout (ack stuck low)
    stuck_s = 1'b1;
    run(8'h5A, 2'b10, 5'b11101, "R8 slave stop timeout");
    stuck_s = 1'b0; settle();
    run(8'h5A, 2'b10, 5'b00011, "R8 recovery disable");

    // R6 master enable timeout (ack stuck high)
    stuck_m = 1'b1;
    run(8'h5A, 2'b01, 5'b10001, "R6 master enable timeout");
    stuck_m = 1'b0; settle();
    run(8'h5A, 2'b10, 5'b00011, "R6 recovery disable");

    // R7 slave enable timeout (ack stuck high)
    stuck_s = 1'b1;
    run(8'h5A, 2'b01, 5'b10010, "R7 slave enable timeout");
    stuck_s = 1'b0; settle();
    run(8'h5A, 2'b10, 5'b00011, "R7 recovery disable");

    // R11: keyed disable held for the whole enable, including the completing cycle
    expq.push_back(5'b01100);
    tagq.push_back("R11 enable with write held");
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = {8'h5A, 22'd0, 2'b01};
    @(negedge clk);
    cmd_data = {8'h5A, 22'd0, 2'b10};
    while (!done) @(negedge clk);
    cmd_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && dom_clk_en && dom_rst_n, "R11 write during busy ignored",
        {busy, dom_clk_en, dom_rst_n}, 3'b011);
    run(8'h5A, 2'b10, 5'b00011, "R11 final disable");

    // R13 bridge-less variant
    run_nb(2'b01, 5'b01111, "R13 no-bridge enable");
    run_nb(2'b11, 5'b01111, "R13 no-bridge pulse");
    run_nb(2'b10, 5'b00011, "R13 no-bridge disable");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R12 all completions seen", expq.size(), 0);
    finish_up();
  end
endmodule